// File: doc/BRIEF.md
# UART Interrupt Enable and Identification Logic

This block is the interrupt control section of a UART with transmit and receive FIFOs. It sits next to the FIFO storage and the register decoder. It takes occupancy counts, push and pop events, receive error flags, register access strobes and the FIFO-mode enable. From these it produces one active-high interrupt line, a 4-bit interrupt status code naming the most urgent enabled source, and the data-ready, transmit-empty and error bits of the line status register.

There are three sources: receive line status, receive ready and transmit empty. Each has its own set and clear rule. Receive ready follows a programmed trigger level in FIFO mode and plain non-emptiness in single-character mode. Transmit empty is a latched event in FIFO mode and a live level in single-character mode. Line errors are sticky until the line status register is read. A 3-bit enable register gates each source.

Top module: `uart_irq_ctrl`

## Requirements
- R1: The enable register `ier` resets to 0b000. A write loads `ier_wdata` into it on the next edge. Bit 0 gates receive ready, bit 1 gates transmit empty and bit 2 gates line status. While `ier` is 0b000, `irq` stays low and `isr` reads 0b0001.
- R2: In FIFO mode (`fifo_en`=1), the receive-ready request is active exactly while `rx_level` >= `rx_trig`. It goes inactive as soon as the level falls below the trigger.
- R3: `lsr_dr` becomes 1 on the edge after an `rx_push`. It stays 1 until an edge at which `rx_level` is 0 and no push occurs, and then it becomes 0.
- R4: In FIFO mode, a `tx_pop` while `tx_level` is 1 (the last character leaves) latches the transmit-empty request. A `thr_wr` clears it unless a new drain event arrives in the same cycle.
- R5: An `isr_rd` clears the latched transmit request only if `isr` shows 0b0010 during that read. A drain event in the same cycle as the read leaves the request pending.
- R6: In single-character mode (`fifo_en`=0), the receive-ready request is active while `rx_level` is not 0. The transmit request is active while `tx_level` is 0. `lsr_thre` always equals (`tx_level` == 0).
- R7: Each `err_in` bit sets the matching sticky `lsr_err` bit. An `lsr_rd` clears all of them, except bits that are set again in the same cycle. The line status request is active while any `lsr_err` bit is 1.
- R8: `isr` reports only the highest-priority enabled pending source. The codes are 0b0110 for line status (highest), 0b0100 for receive ready, 0b0010 for transmit empty (lowest) and 0b0001 for none.
- R9: `irq` is registered. It is 1 exactly when `isr` is not 0b0001, and both take their values from the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fifo_en | input | 1 | 1 selects FIFO mode, 0 selects single-character mode |
| rx_level | input | CNT_W | Receive FIFO or holding register occupancy |
| rx_trig | input | CNT_W | Receive trigger level |
| rx_push | input | 1 | A character entered the receive FIFO |
| tx_level | input | CNT_W | Transmit FIFO or holding register occupancy |
| tx_pop | input | 1 | The shift register took a character from the transmit FIFO |
| err_in | input | 4 | Receive error flags for the current cycle |
| ier_we | input | 1 | Write strobe for the enable register |
| ier_wdata | input | 3 | Enable register write data |
| isr_rd | input | 1 | Interrupt status register read strobe |
| lsr_rd | input | 1 | Line status register read strobe |
| thr_wr | input | 1 | Transmit holding register write strobe |
| ier | output | 3 | Enable register contents |
| isr | output | 4 | Interrupt status code |
| irq | output | 1 | Interrupt request, active high |
| lsr_dr | output | 1 | Receive data ready |
| lsr_thre | output | 1 | Transmit holding empty |
| lsr_err | output | 4 | Sticky receive error bits |

## Verification
`lsr_thre` is combinational and follows `tx_level` in the same cycle. All other outputs are registered and reflect the inputs present before the edge that loads them. A write to the enable register is seen in `isr` one edge later than it is seen in `ier`. The bench drives inputs on the falling edge and runs a behavioural model on the rising edge. It compares every output at the next falling edge, so each result is checked in the cycle it falls due. Directed checks read `isr` one cycle after each pulse, which covers the same-cycle collisions of a read with a new event.

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_en,
  input  logic [CNT_W-1:0] rx_level,
  input  logic [CNT_W-1:0] rx_trig,
  input  logic             rx_push,
  input  logic [CNT_W-1:0] tx_level,
  input  logic             tx_pop,
  input  logic [3:0]       err_in,
  input  logic             ier_we,
  input  logic [2:0]       ier_wdata,
  input  logic             isr_rd,
  input  logic             lsr_rd,
  input  logic             thr_wr,
  output logic [2:0]       ier,
  output logic [3:0]       isr,
  output logic             irq,
  output logic             lsr_dr,
  output logic             lsr_thre,
  output logic [3:0]       lsr_err
);
  localparam logic [3:0] CODE_LS   = 4'b0110;
  localparam logic [3:0] CODE_RX   = 4'b0100;
  localparam logic [3:0] CODE_TX   = 4'b0010;
  localparam logic [3:0] CODE_NONE = 4'b0001;

  logic       tx_pend;
  logic       tx_set, tx_clr, tx_pend_d;
  logic [3:0] err_d, isr_d;
  logic       rx_req, tx_req;

  assign lsr_thre  = (tx_level == '0);
  assign tx_set    = tx_pop && (tx_level == CNT_W'(1));
  assign tx_clr    = thr_wr || (isr_rd && isr == CODE_TX);
  assign tx_pend_d = tx_set ? 1'b1 : (tx_clr ? 1'b0 : tx_pend);
  assign err_d     = lsr_rd ? err_in : (lsr_err | err_in);
  assign rx_req    = fifo_en ? (rx_level >= rx_trig) : (rx_level != '0);
  assign tx_req    = fifo_en ? tx_pend_d : lsr_thre;

  always_comb begin
    if (ier[2] && err_d != 4'b0000) isr_d = CODE_LS;
    else if (ier[0] && rx_req)      isr_d = CODE_RX;
    else if (ier[1] && tx_req)      isr_d = CODE_TX;
    else                            isr_d = CODE_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ier     <= 3'b000;
      isr     <= CODE_NONE;
      irq     <= 1'b0;
      lsr_dr  <= 1'b0;
      lsr_err <= 4'b0000;
      tx_pend <= 1'b0;
    end else begin
      if (ier_we) ier <= ier_wdata;
      isr     <= isr_d;
      irq     <= (isr_d != CODE_NONE);
      lsr_dr  <= rx_push || (lsr_dr && rx_level != '0);
      lsr_err <= err_d;
      tx_pend <= tx_pend_d;
    end
  end

  assert_ier_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ier_we |=> ier == $past(ier_wdata));
  assert_dr_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |=> lsr_dr);
  assert_thr_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_wr && !(tx_pop && tx_level == CNT_W'(1))) |=> !tx_pend);
  assert_drain_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_pop && tx_level == CNT_W'(1)) |=> tx_pend);
  assert_err_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_rd && err_in == 4'b0000) |=> lsr_err == 4'b0000);
  assert_isr_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (isr == CODE_LS || isr == CODE_RX || isr == CODE_TX || isr == CODE_NONE));
  assert_irq_match_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (isr != CODE_NONE));
endmodule

// File: tb/tb_uart_irq_ctrl.sv
`timescale 1ns/1ps
module tb_uart_irq_ctrl;
  localparam int W = 6;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fifo_en = 1'b0;
  logic [W-1:0] rx_level = '0, rx_trig = '0, tx_level = '0;
  logic rx_push = 0, tx_pop = 0, ier_we = 0, isr_rd = 0, lsr_rd = 0, thr_wr = 0;
  logic [3:0] err_in = '0;
  logic [2:0] ier_wdata = '0;
  logic [2:0] ier;
  logic [3:0] isr, lsr_err;
  logic irq, lsr_dr, lsr_thre;

  int checks = 0, fails = 0;
  int m_ier = 0, m_isr = 1, m_err = 0;
  bit m_pend = 0, m_dr = 0, m_irq = 0;

  always #10 clk = ~clk;

  uart_irq_ctrl #(.CNT_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .rx_level(rx_level),
    .rx_trig(rx_trig), .rx_push(rx_push), .tx_level(tx_level), .tx_pop(tx_pop),
    .err_in(err_in), .ier_we(ier_we), .ier_wdata(ier_wdata), .isr_rd(isr_rd),
    .lsr_rd(lsr_rd), .thr_wr(thr_wr), .ier(ier), .isr(isr), .irq(irq),
    .lsr_dr(lsr_dr), .lsr_thre(lsr_thre), .lsr_err(lsr_err));

  // behavioural reference, evaluated on the same edge as the design
  always @(posedge clk) begin
    if (rst_n) begin
      int e, code;
      bit p, rq, tq;
      e = lsr_rd ? int'(err_in) : (m_err | int'(err_in));
      if (tx_pop && tx_level == 1) p = 1;
      else if (thr_wr || (isr_rd && m_isr == 2)) p = 0;
      else p = m_pend;
      if (fifo_en) begin rq = (rx_level >= rx_trig); tq = p; end
      else begin rq = (rx_level != 0); tq = (tx_level == 0); end
      if ((m_ier & 4) != 0 && e != 0) code = 6;
      else if ((m_ier & 1) != 0 && rq) code = 4;
      else if ((m_ier & 2) != 0 && tq) code = 2;
      else code = 1;
      m_dr = rx_push || (m_dr && rx_level != 0);
      m_err = e; m_pend = p; m_isr = code; m_irq = (code != 1);
      if (ier_we) m_ier = int'(ier_wdata);
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R1 ier", int'(ier), m_ier);
    chk("R8 isr", int'(isr), m_isr);
    chk("R9 irq", int'(irq), int'(m_irq));
    chk("R3 lsr_dr", int'(lsr_dr), int'(m_dr));
    chk("R7 lsr_err", int'(lsr_err), m_err);
    chk("R6 lsr_thre", int'(lsr_thre), int'(tx_level == 0));
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
    compare_all();
    rx_push = 0; tx_pop = 0; ier_we = 0; isr_rd = 0; lsr_rd = 0; thr_wr = 0; err_in = '0;
  endtask

  task automatic set_ier(input logic [2:0] v);
    ier_we = 1; ier_wdata = v; step(); step();
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #2000000;
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset ier", int'(ier), 0);
    chk("R8 reset isr", int'(isr), 1);
    chk("R9 reset irq", int'(irq), 0);
    rst_n = 1;
    tx_level = 3; rx_level = 5;
    step();
    chk("R1 disabled irq low", int'(irq), 0);

    // R2 trigger threshold in FIFO mode
    fifo_en = 1; rx_trig = 4; rx_level = 3;
    set_ier(3'b001);
    chk("R2 below trigger", int'(isr), 1);
    rx_level = 4; step();
    chk("R2 at trigger", int'(isr), 4);
    rx_level = 3; step();
    chk("R2 drop below", int'(isr), 1);

    // R4 drain event and holding register write
    rx_level = 0; set_ier(3'b010);
    tx_level = 1; tx_pop = 1; step(); tx_level = 0;
    chk("R4 drain sets", int'(isr), 2);
    thr_wr = 1; step();
    chk("R4 thr write clears", int'(isr), 1);

    // R5 read collides with drain, then plain read
    tx_level = 1; tx_pop = 1; step();
    tx_level = 1; tx_pop = 1; isr_rd = 1; step(); tx_level = 0;
    chk("R5 same-cycle drain kept", int'(isr), 2);
    isr_rd = 1; step();
    chk("R5 read clears", int'(isr), 1);

    // R5 read while receive ready is reported keeps transmit pending
    set_ier(3'b011);
    tx_level = 1; tx_pop = 1; rx_level = 6; step(); tx_level = 0;
    chk("R8 rx over tx", int'(isr), 4);
    isr_rd = 1; step();
    rx_level = 0; step();
    chk("R5 tx survives rx read", int'(isr), 2);
    isr_rd = 1; step();

    // R7 sticky errors and priority
    set_ier(3'b111);
    rx_level = 6; err_in = 4'b0100; step();
    chk("R7 error set", int'(lsr_err), 4);
    chk("R8 line status top", int'(isr), 6);
    lsr_rd = 1; err_in = 4'b0001; step();
    chk("R7 same-cycle error kept", int'(lsr_err), 1);
    lsr_rd = 1; step();
    chk("R7 read clears", int'(lsr_err), 0);
    chk("R8 falls to rx", int'(isr), 4);

    // R6 single-character mode
    fifo_en = 0; rx_level = 0; tx_level = 0; step();
    chk("R6 tx empty level", int'(isr), 2);
    rx_level = 1; step();
    chk("R6 rx holds data", int'(isr), 4);
    rx_level = 0; tx_level = 1; step();
    chk("R6 none pending", int'(isr), 1);

    // R3 data ready
    rx_push = 1; step();
    chk("R3 push sets dr", int'(lsr_dr), 1);
    rx_level = 1; step(); rx_level = 0; step();
    chk("R3 empty clears dr", int'(lsr_dr), 0);

    // mixed traffic against the model
    for (int i = 0; i < 3000; i++) begin
      fifo_en = ($urandom % 8) != 0;
      rx_level = W'($urandom % 8); rx_trig = W'(1 + $urandom % 6);
      tx_level = W'($urandom % 3);
      rx_push = ($urandom % 4) == 0; tx_pop = ($urandom % 3) == 0;
      err_in = (($urandom % 6) == 0) ? 4'($urandom) : 4'b0000;
      ier_we = ($urandom % 16) == 0; ier_wdata = 3'($urandom);
      isr_rd = ($urandom % 4) == 0; lsr_rd = ($urandom % 5) == 0;
      thr_wr = ($urandom % 6) == 0;
      @(posedge clk); @(negedge clk);
      compare_all();
    end
    finish_run();
  end
endmodule